// File: doc/BRIEF.md
# Video Frame Timing Sequencer

This block paces one video frame for a serial display link that runs in burst mode with sync pulses. Horizontal intervals are counted in lane byte clock cycles, one count per `clk` cycle, and vertical intervals are counted in lines. The configuration inputs set the timing. They give the horizontal sync width, the horizontal back porch, the total line time and the active packet duration. They also give the line counts for vertical sync, vertical back porch, vertical active and vertical front porch. The horizontal front porch has no input of its own. It is whatever is left of the line.

The downstream packet engine receives three one-cycle markers: sync start, sync end and an active-packet request. It also receives level outputs for hsync, vsync and data enable, each with a selectable polarity. A last output tells the lane logic when it may drop to low-power mode during blanking. All configuration is copied into shadow registers when a frame starts, so software may rewrite it at any time.

The frame controller has five states. `RG_IDLE` is not sequencing. `RG_VSYNC`, `RG_VBACK`, `RG_VACT` and `RG_VFRONT` are the vertical regions. The transitions are:
- **start**: IDLE goes to the first region of the frame when `run_i` is high and the mode code is 2.
- **advance**: a region goes to the next non-empty region on its last line.
- **wrap**: at frame end the controller goes back to the first region, or to IDLE if the mode is no longer 2.
- **stop**: any state goes to IDLE when `run_i` is low.

Top module: `vtg_frame_seq`

## Requirements
- R1: With `run_i` high, sequencing starts only when `mode_i` equals 2 (burst with sync pulses). While idle, the outputs behave as follows:
  - the pulse outputs and `lp_allow_o` are 0;
  - each level output sits at its inactive level.
- R2: Every line lasts L byte clocks, where L = max(line time, sync + back porch + packet, 1). The horizontal front porch is never negative.
- R3: Within each line:
  - `hsync` is active for the first `hsa_i` cycles of every line.
  - `hs_start_o` pulses at cycle 0 and `hs_end_o` pulses at cycle `hsa_i`-1.
  - When the sync width is 0, neither marker pulses.
- R4: A frame runs through the vertical regions in this order: sync lines, back porch lines, active lines, front porch lines, then it wraps.
  - A region with a count of 0 is skipped.
  - An active count of 0 is treated as one line.
- R5: On active lines:
  - `pkt_req_o` pulses at cycle `hsa_i`+`hbp_i` when the packet duration is nonzero.
  - `de` is active for `pkt_i` cycles starting at that cycle.
  - Blanking lines carry neither.
- R6: `vsync` is active for every cycle of every vertical sync line.
- R7: `pol_i` bit 2 makes hsync active low, bit 1 makes vsync active low, and bit 0 makes data enable active low.
- R8: `lp_allow_o` follows `lp_mask_i`, one bit per blanking region:
  - bit 0 covers sync lines, bit 1 back porch lines and bit 2 front porch lines.
  - On active lines, bit 3 AND bit 4 cover the horizontal back porch, and bit 3 AND bit 5 cover the horizontal front porch.
  - It is never 1 during hsync or during the packet.
- R9: Configuration and mode are sampled only at a frame start. A change made mid-frame takes effect from the next frame. A mode other than 2 seen at a frame end stops the sequencer.
- R10: When `run_i` goes low, the block is idle from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Sequencer enable |
| mode_i | input | 2 | Video mode type; 2 = burst with sync pulses |
| pol_i | input | 3 | Active-low selects: [2] hsync, [1] vsync, [0] data enable |
| lp_mask_i | input | 6 | Low-power permission per blanking region |
| hsa_i | input | HW | Horizontal sync width, byte clocks |
| hbp_i | input | HW | Horizontal back porch, byte clocks |
| hline_i | input | HW | Total line time, byte clocks |
| pkt_i | input | PW | Active packet duration, byte clocks |
| vsa_i | input | VW | Vertical sync lines |
| vbp_i | input | VW | Vertical back porch lines |
| vfp_i | input | VW | Vertical front porch lines |
| vact_i | input | VW | Active lines |
| hsync_o | output | 1 | Horizontal sync level, polarity applied |
| vsync_o | output | 1 | Vertical sync level, polarity applied |
| de_o | output | 1 | Data enable level, polarity applied |
| hs_start_o | output | 1 | One-cycle marker at line start when sync width is nonzero |
| hs_end_o | output | 1 | One-cycle marker on the last sync cycle |
| pkt_req_o | output | 1 | One-cycle active packet request |
| lp_allow_o | output | 1 | Low-power entry allowed this cycle |

## Verification
The bench targets the following corner cases:
- **Overlong packet.** A packet too long for the programmed line time must stretch the line. A design that wraps at the line time would cut the packet and misplace the next sync.
- **Zero-length regions.** A region with no lines must be skipped. A design that fails here would emit a stray sync line or hang on a count of zero.
- **Active count of zero.** It must still give one active line; an error shows up as a missing packet request.
- **Sync width of zero.** It must suppress both markers.
- **Mid-frame changes.** Configuration, polarity and mode changes made mid-frame are checked to land exactly at the next frame start. A design that applies them at once shows a wrong packet count for the current frame.
- **Stop on `run_i` low.** Dropping `run_i` must idle the outputs within one cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [2:0] {
        RG_IDLE   = 3'd0,
        RG_VSYNC  = 3'd1,
        RG_VBACK  = 3'd2,
        RG_VACT   = 3'd3,
        RG_VFRONT = 3'd4
    } region_e;

    localparam logic [1:0] MODE_BURST_PULSE = 2'd2;

    // First non-empty region of a frame; the active region is never empty.
    function automatic region_e first_region(input logic vsa_nz, input logic vbp_nz);
        if (vsa_nz)      return RG_VSYNC;
        else if (vbp_nz) return RG_VBACK;
        else             return RG_VACT;
    endfunction

    // Region after the current one when the frame is not ending.
    function automatic region_e after_region(input region_e cur, input logic vbp_nz);
        region_e nxt;
        case (cur)
            RG_VSYNC: nxt = vbp_nz ? RG_VBACK : RG_VACT;
            RG_VBACK: nxt = RG_VACT;
            RG_VACT:  nxt = RG_VFRONT;
            default:  nxt = RG_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/vtg_cfg_shadow.sv
module vtg_cfg_shadow #(
    parameter int HW = 16,
    parameter int PW = 14,
    parameter int VW = 11,
    parameter int LW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [2:0]    pol_i,
    input  logic [5:0]    mask_i,
    input  logic [HW-1:0] hsa_i,
    input  logic [HW-1:0] hbp_i,
    input  logic [HW-1:0] hline_i,
    input  logic [PW-1:0] pkt_i,
    input  logic [VW-1:0] vsa_i,
    input  logic [VW-1:0] vbp_i,
    input  logic [VW-1:0] vfp_i,
    input  logic [VW-1:0] vact_i,
    output logic [2:0]    s_pol,
    output logic [5:0]    s_mask,
    output logic [HW-1:0] s_hsa,
    output logic [HW-1:0] s_hbp,
    output logic [PW-1:0] s_pkt,
    output logic [VW-1:0] s_vsa,
    output logic [VW-1:0] s_vbp,
    output logic [VW-1:0] s_vfp,
    output logic [VW-1:0] s_vact,
    output logic [LW-1:0] s_len
);

    logic [LW-1:0] busy_w;
    logic [LW-1:0] len_w;

    // Line length: the larger of the programmed line time and the
    // sync+porch+packet sum, never below one cycle.
    always_comb begin
        busy_w = LW'(hsa_i) + LW'(hbp_i) + LW'(pkt_i);
        len_w  = (LW'(hline_i) > busy_w) ? LW'(hline_i) : busy_w;
        if (len_w == '0) begin
            len_w = LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_pol  <= '0;
            s_mask <= '0;
            s_hsa  <= '0;
            s_hbp  <= '0;
            s_pkt  <= '0;
            s_vsa  <= '0;
            s_vbp  <= '0;
            s_vfp  <= '0;
            s_vact <= '0;
            s_len  <= LW'(1);
        end else if (load) begin
            s_pol  <= pol_i;
            s_mask <= mask_i;
            s_hsa  <= hsa_i;
            s_hbp  <= hbp_i;
            s_pkt  <= pkt_i;
            s_vsa  <= vsa_i;
            s_vbp  <= vbp_i;
            s_vfp  <= vfp_i;
            s_vact <= vact_i;
            s_len  <= len_w;
        end
    end

    // R9: shadow values hold between loads
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(s_len) && $stable(s_vact) && $stable(s_pol) && $stable(s_mask)));

endmodule

// File: rtl/vtg_line_timer.sv
module vtg_line_timer #(
    parameter int LW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [LW-1:0] line_len,
    output logic [LW-1:0] hcnt,
    output logic          line_last
);

    assign line_last = !hold && (hcnt == line_len - LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (hold || line_last) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + LW'(1);
        end
    end

    // R2: the position never leaves the line
    a_r2_within_line: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (hcnt < line_len));

endmodule

// File: rtl/vtg_frame_fsm.sv
module vtg_frame_fsm
    import vtg_pkg::*;
#(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    live_mode,
    input  logic          live_vsa_nz,
    input  logic          live_vbp_nz,
    input  logic [VW-1:0] s_vsa,
    input  logic [VW-1:0] s_vbp,
    input  logic [VW-1:0] s_vfp,
    input  logic [VW-1:0] s_vact,
    input  logic          line_last,
    output region_e       region,
    output logic          frame_end,
    output logic          shadow_load
);

    region_e       region_q, region_d;
    logic [VW-1:0] lcnt_q, lcnt_d;
    logic [VW-1:0] cur_cnt;
    logic          last_line;
    logic          mode_ok;

    assign mode_ok = (live_mode == MODE_BURST_PULSE);

    always_comb begin
        unique case (region_q)
            RG_VSYNC:  cur_cnt = s_vsa;
            RG_VBACK:  cur_cnt = s_vbp;
            RG_VACT:   cur_cnt = (s_vact == '0) ? VW'(1) : s_vact;
            RG_VFRONT: cur_cnt = s_vfp;
            default:   cur_cnt = VW'(1);
        endcase
    end

    assign last_line = (lcnt_q == cur_cnt - VW'(1));
    assign frame_end = line_last && last_line &&
                       ((region_q == RG_VFRONT) || ((region_q == RG_VACT) && (s_vfp == '0)));

    // next-state logic
    always_comb begin
        region_d = region_q;
        lcnt_d   = lcnt_q;
        if (!run) begin
            region_d = RG_IDLE;
            lcnt_d   = '0;
        end else begin
            unique case (region_q)
                RG_IDLE: begin
                    lcnt_d = '0;
                    if (mode_ok) begin
                        region_d = first_region(live_vsa_nz, live_vbp_nz);
                    end
                end
                RG_VSYNC, RG_VBACK, RG_VACT, RG_VFRONT: begin
                    if (line_last) begin
                        if (last_line) begin
                            lcnt_d = '0;
                            if (frame_end) begin
                                region_d = mode_ok ? first_region(live_vsa_nz, live_vbp_nz)
                                                   : RG_IDLE;
                            end else begin
                                region_d = after_region(region_q, s_vbp != '0);
                            end
                        end else begin
                            lcnt_d = lcnt_q + VW'(1);
                        end
                    end
                end
                default: begin
                    region_d = RG_IDLE;
                    lcnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region_q <= RG_IDLE;
            lcnt_q   <= '0;
        end else begin
            region_q <= region_d;
            lcnt_q   <= lcnt_d;
        end
    end

    assign region      = region_q;
    assign shadow_load = !run || (region_q == RG_IDLE) || frame_end;

    // R10: dropping run idles the controller on the next cycle
    a_r10_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (region_q == RG_IDLE));

    // R1: idle persists while the mode code is not burst-with-pulses
    a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((region_q == RG_IDLE) && !mode_ok) |=> (region_q == RG_IDLE));

endmodule

// File: rtl/vtg_frame_seq.sv
module vtg_frame_seq
    import vtg_pkg::*;
#(
    parameter int HW = 16,
    parameter int PW = 14,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [1:0]    mode_i,
    input  logic [2:0]    pol_i,
    input  logic [5:0]    lp_mask_i,
    input  logic [HW-1:0] hsa_i,
    input  logic [HW-1:0] hbp_i,
    input  logic [HW-1:0] hline_i,
    input  logic [PW-1:0] pkt_i,
    input  logic [VW-1:0] vsa_i,
    input  logic [VW-1:0] vbp_i,
    input  logic [VW-1:0] vfp_i,
    input  logic [VW-1:0] vact_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          hs_start_o,
    output logic          hs_end_o,
    output logic          pkt_req_o,
    output logic          lp_allow_o
);

    localparam int LW = ((HW > PW) ? HW : PW) + 2;

    logic [2:0]    s_pol;
    logic [5:0]    s_mask;
    logic [HW-1:0] s_hsa, s_hbp;
    logic [PW-1:0] s_pkt;
    logic [VW-1:0] s_vsa, s_vbp, s_vfp, s_vact;
    logic [LW-1:0] s_len;
    logic [LW-1:0] hcnt;
    logic          line_last;
    logic          frame_end;
    logic          shadow_load;
    region_e       region;

    logic          hs_act, vs_act, de_act;
    logic          hs_start, hs_end, req, lp;
    logic [LW-1:0] sync_w, act_beg, act_end;

    vtg_cfg_shadow #(.HW(HW), .PW(PW), .VW(VW), .LW(LW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (shadow_load),
        .pol_i   (pol_i),
        .mask_i  (lp_mask_i),
        .hsa_i   (hsa_i),
        .hbp_i   (hbp_i),
        .hline_i (hline_i),
        .pkt_i   (pkt_i),
        .vsa_i   (vsa_i),
        .vbp_i   (vbp_i),
        .vfp_i   (vfp_i),
        .vact_i  (vact_i),
        .s_pol   (s_pol),
        .s_mask  (s_mask),
        .s_hsa   (s_hsa),
        .s_hbp   (s_hbp),
        .s_pkt   (s_pkt),
        .s_vsa   (s_vsa),
        .s_vbp   (s_vbp),
        .s_vfp   (s_vfp),
        .s_vact  (s_vact),
        .s_len   (s_len)
    );

    vtg_line_timer #(.LW(LW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (region == RG_IDLE),
        .line_len  (s_len),
        .hcnt      (hcnt),
        .line_last (line_last)
    );

    vtg_frame_fsm #(.VW(VW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_i),
        .live_mode   (mode_i),
        .live_vsa_nz (vsa_i != '0),
        .live_vbp_nz (vbp_i != '0),
        .s_vsa       (s_vsa),
        .s_vbp       (s_vbp),
        .s_vfp       (s_vfp),
        .s_vact      (s_vact),
        .line_last   (line_last),
        .region      (region),
        .frame_end   (frame_end),
        .shadow_load (shadow_load)
    );

    assign sync_w  = LW'(s_hsa);
    assign act_beg = LW'(s_hsa) + LW'(s_hbp);
    assign act_end = act_beg + LW'(s_pkt);

    // output decode from region and line position
    always_comb begin
        hs_act   = 1'b0;
        vs_act   = 1'b0;
        de_act   = 1'b0;
        hs_start = 1'b0;
        hs_end   = 1'b0;
        req      = 1'b0;
        lp       = 1'b0;
        if (region != RG_IDLE) begin
            hs_act   = (hcnt < sync_w);
            hs_start = (s_hsa != '0) && (hcnt == '0);
            hs_end   = (s_hsa != '0) && (hcnt == sync_w - LW'(1));
        end
        unique case (region)
            RG_IDLE: ;
            RG_VSYNC: begin
                vs_act = 1'b1;
                lp     = !hs_act && s_mask[0];
            end
            RG_VBACK: lp = !hs_act && s_mask[1];
            RG_VFRONT: lp = !hs_act && s_mask[2];
            RG_VACT: begin
                de_act = (hcnt >= act_beg) && (hcnt < act_end);
                req    = (s_pkt != '0) && (hcnt == act_beg);
                lp     = !hs_act && !de_act && s_mask[3] &&
                         ((hcnt < act_beg) ? s_mask[4] : s_mask[5]);
            end
            default: ;
        endcase
    end

    assign hsync_o    = hs_act ^ s_pol[2];
    assign vsync_o    = vs_act ^ s_pol[1];
    assign de_o       = de_act ^ s_pol[0];
    assign hs_start_o = hs_start;
    assign hs_end_o   = hs_end;
    assign pkt_req_o  = req;
    assign lp_allow_o = lp;

    // R1: nothing is emitted while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_IDLE) |-> (!hs_start_o && !hs_end_o && !pkt_req_o && !lp_allow_o));

    // R8: low-power never overlaps sync
    a_r8_no_lp_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        hs_act |-> !lp_allow_o);

    // R6: vertical sync begins on a line boundary
    a_r6_vs_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act) |-> (hcnt == '0));

    // R6: vertical sync ends on a line boundary or on stop
    a_r6_vs_fall_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_act) |-> ((hcnt == '0) || (region == RG_IDLE)));

endmodule

// File: tb/sim_vtg_frame_seq.sv
module sim_vtg_frame_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [2:0]  pol_i = 3'd0;
    logic [5:0]  lp_mask_i = 6'd0;
    logic [15:0] hsa_i = '0, hbp_i = '0, hline_i = '0;
    logic [13:0] pkt_i = '0;
    logic [10:0] vsa_i = '0, vbp_i = '0, vfp_i = '0, vact_i = '0;
    logic        hsync_o, vsync_o, de_o, hs_start_o, hs_end_o, pkt_req_o, lp_allow_o;

    int total = 0;
    int bad = 0;
    bit fin = 0;

    int n_hs = 0, n_he = 0, n_pkt = 0, n_vs = 0, n_de = 0;

    vtg_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_i(mode_i), .pol_i(pol_i),
        .lp_mask_i(lp_mask_i), .hsa_i(hsa_i), .hbp_i(hbp_i), .hline_i(hline_i),
        .pkt_i(pkt_i), .vsa_i(vsa_i), .vbp_i(vbp_i), .vfp_i(vfp_i), .vact_i(vact_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .hs_start_o(hs_start_o),
        .hs_end_o(hs_end_o), .pkt_req_o(pkt_req_o), .lp_allow_o(lp_allow_o)
    );

    always #2.5ns clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_active = 0, m_h = 0, m_li = 0, m_len = 1;
    int s_hsa = 0, s_hbp = 0, s_hline = 0, s_pkt = 0;
    int s_vsa = 0, s_vbp = 0, s_vfp = 0, s_vact = 0;
    int s_pol = 0, s_mask = 0;
    int lines[$];

    task automatic m_latch();
        s_hsa = hsa_i; s_hbp = hbp_i; s_hline = hline_i; s_pkt = pkt_i;
        s_vsa = vsa_i; s_vbp = vbp_i; s_vfp = vfp_i; s_vact = vact_i;
        s_pol = pol_i; s_mask = lp_mask_i;
    endtask

    task automatic m_build();
        int busy;
        lines.delete();
        for (int i = 0; i < s_vsa; i++) lines.push_back(0);
        for (int i = 0; i < s_vbp; i++) lines.push_back(1);
        for (int i = 0; i < ((s_vact == 0) ? 1 : s_vact); i++) lines.push_back(3);
        for (int i = 0; i < s_vfp; i++) lines.push_back(2);
        busy = s_hsa + s_hbp + s_pkt;
        m_len = (s_hline > busy) ? s_hline : busy;
        if (m_len < 1) m_len = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_h = 0; m_li = 0; s_pol = 0; s_mask = 0;
        end else if (!run_i) begin
            m_active = 0;
        end else if (m_active == 0) begin
            m_latch();
            if (mode_i == 2'd2) begin
                m_build(); m_active = 1; m_h = 0; m_li = 0;
            end
        end else if (m_h == m_len - 1) begin
            m_h = 0;
            m_li++;
            if (m_li >= lines.size()) begin
                m_latch();
                if (mode_i != 2'd2) m_active = 0;
                else begin m_build(); m_li = 0; end
            end
        end else begin
            m_h++;
        end
        if (rst_n && m_active == 0) m_latch();
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int e_hs, e_vs, e_de, e_st, e_en, e_rq, e_lp, rg, a0;
            e_hs = 0; e_vs = 0; e_de = 0; e_st = 0; e_en = 0; e_rq = 0; e_lp = 0;
            if (m_active != 0) begin
                rg = lines[m_li];
                a0 = s_hsa + s_hbp;
                e_hs = (m_h < s_hsa) ? 1 : 0;
                e_st = (s_hsa > 0 && m_h == 0) ? 1 : 0;
                e_en = (s_hsa > 0 && m_h == s_hsa - 1) ? 1 : 0;
                e_vs = (rg == 0) ? 1 : 0;
                if (rg == 3) begin
                    e_de = (m_h >= a0 && m_h < a0 + s_pkt) ? 1 : 0;
                    e_rq = (s_pkt > 0 && m_h == a0) ? 1 : 0;
                end
                if (e_hs == 0 && e_de == 0) begin
                    case (rg)
                        0: e_lp = s_mask & 1;
                        1: e_lp = (s_mask >> 1) & 1;
                        2: e_lp = (s_mask >> 2) & 1;
                        default: e_lp = ((s_mask >> 3) & 1) &
                                        ((m_h < a0) ? ((s_mask >> 4) & 1) : ((s_mask >> 5) & 1));
                    endcase
                end
            end
            chk("R3/R7 hsync level", hsync_o, e_hs ^ ((s_pol >> 2) & 1));
            chk("R6/R7 vsync level", vsync_o, e_vs ^ ((s_pol >> 1) & 1));
            chk("R5/R7 data enable", de_o, e_de ^ (s_pol & 1));
            chk("R3 sync start", hs_start_o, e_st);
            chk("R3 sync end", hs_end_o, e_en);
            chk("R5 packet request", pkt_req_o, e_rq);
            chk("R8 low-power allow", lp_allow_o, e_lp);
            if (hs_start_o) n_hs++;
            if (hs_end_o) n_he++;
            if (pkt_req_o) n_pkt++;
            if (vsync_o ^ s_pol[1]) n_vs++;
            if (de_o ^ s_pol[0]) n_de++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1ns;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #100us;
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int b_hs, b_he, b_pkt, b_vs, b_de;
        step(3);
        // R1: reset state
        chk("R1 reset hsync", hsync_o, 0);
        chk("R1 reset vsync", vsync_o, 0);
        chk("R1 reset de", de_o, 0);
        chk("R1 reset pulses", hs_start_o | hs_end_o | pkt_req_o, 0);
        chk("R1 reset lp", lp_allow_o, 0);
        rst_n = 1'b1;

        // R1: run with a different mode code stays idle
        hsa_i = 4; hbp_i = 3; hline_i = 30; pkt_i = 10;
        vsa_i = 2; vbp_i = 2; vact_i = 3; vfp_i = 2; lp_mask_i = 6'h3F;
        mode_i = 2'd1; run_i = 1'b1;
        b_hs = n_hs; step(20);
        chk("R1 wrong mode no markers", n_hs - b_hs, 0);

        // main frames
        mode_i = 2'd2;
        b_hs = n_hs; b_he = n_he; b_pkt = n_pkt; b_vs = n_vs; b_de = n_de;
        step(1);
        chk("R4 frame opens in sync region", vsync_o, 1);
        step(539);
        chk("R3 sync starts over two frames", n_hs - b_hs, 18);
        chk("R3 sync ends over two frames", n_he - b_he, 18);
        chk("R5 packets over two frames", n_pkt - b_pkt, 6);
        chk("R6 vsync cycles", n_vs - b_vs, 120);
        chk("R5 de cycles", n_de - b_de, 60);

        // R9: mid-frame change waits for next frame
        step(100);
        vact_i = 5; pol_i = 3'b111; lp_mask_i = 6'b010101;
        b_pkt = n_pkt; step(170);
        chk("R9 current frame keeps old count", n_pkt - b_pkt, 3);
        b_pkt = n_pkt; step(1);
        chk("R7 vsync active low", vsync_o, 0);
        chk("R7 hsync active low", hsync_o, 0);
        chk("R7 de idle high", de_o, 1);
        step(329);
        chk("R9 new count in next frame", n_pkt - b_pkt, 5);

        // R9: mode change takes effect at frame end
        b_pkt = n_pkt; step(10);
        mode_i = 2'd1;
        step(320);
        chk("R9 frame completes after mode change", n_pkt - b_pkt, 5);
        b_hs = n_hs; step(30);
        chk("R1 stopped after frame end", n_hs - b_hs, 0);

        // R2: overlong packet stretches the line; R4 skip empty regions
        pol_i = 3'b000; lp_mask_i = 6'b101010;
        hsa_i = 3; hbp_i = 2; hline_i = 10; pkt_i = 8;
        vsa_i = 1; vbp_i = 0; vact_i = 2; vfp_i = 0;
        mode_i = 2'd2;
        b_hs = n_hs; b_pkt = n_pkt; b_de = n_de;
        step(39);
        chk("R2 three lines of 13 cycles", n_hs - b_hs, 3);
        chk("R4 two active lines", n_pkt - b_pkt, 2);
        chk("R2 full packet kept", n_de - b_de, 16);
        step(20);

        // R10: stop at once
        run_i = 1'b0;
        step(1);
        chk("R10 no request after stop", pkt_req_o, 0);
        chk("R10 no lp after stop", lp_allow_o, 0);
        chk("R10 hsync inactive after stop", hsync_o, 0);
        chk("R10 de inactive after stop", de_o, 0);
        b_hs = n_hs; step(5);
        chk("R10 no markers while stopped", n_hs - b_hs, 0);

        // R3 zero sync width, R4 zero active count
        hsa_i = 0; hbp_i = 2; hline_i = 8; pkt_i = 3;
        vsa_i = 0; vbp_i = 1; vact_i = 0; vfp_i = 1;
        lp_mask_i = 6'b011001; pol_i = 3'b100;
        run_i = 1'b1;
        b_hs = n_hs; b_pkt = n_pkt; b_vs = n_vs;
        step(48);
        chk("R3 no markers with zero sync", n_hs - b_hs, 0);
        chk("R4 zero active count gives one line", n_pkt - b_pkt, 2);
        chk("R6 no vsync when sync region empty", n_vs - b_vs, 0);

        run_i = 1'b0;
        step(2);
        fin = 1;
        summary();
        $finish;
    end

endmodule